// File: doc/BRIEF.md
# Motor Speed Discriminator with Lock Detect

This block closes the digital half of a brushless-motor speed servo. It counts reference ticks across each tachometer period and compares the result with a target count. Two mode pins choose the target count and the rate of the reference tick. Once in every two tachometer periods it emits a signed speed error with a one-cycle strobe. A drive stage downstream uses that error to trim its duty. An active-low lock flag reports when the last measurement fell inside a ±1/16 window around the target.

The reference tick comes from a fractional accumulator. Each clock it adds the selected divisor, and it produces a tick when the sum overflows 2^10. The tick rate is therefore clock × divisor / 1024, and the target tachometer period is count × 1024 / divisor clocks. Changing from one mode pair to another can halve the servo speed without touching the clock.

A three-state machine sequences the measurement. ST_WAIT ignores all tachometer activity until the first synchronized rising edge arrives (transition WAIT→FIRST). ST_FIRST times the first period of a pair, which is never reported (transition FIRST→SECOND on the next rising edge). ST_SECOND times the period that is reported. On its closing edge the machine emits and returns to ST_FIRST (transition SECOND→FIRST). A change of the synchronized mode pins forces ST_WAIT from any state (transition ANY→WAIT).

Top module: `spd_disc`

## Requirements
- R1: Mode pins {mode_a, mode_b} select the (count, divisor) pair: 11 → (1024, 1024), 10 → (1024, 512), 01 → (256, 256), 00 → (512, 512). The zero-error tachometer period is 1024 clocks in modes 11, 01 and 00, and 2048 clocks in mode 10.
- R2: spd_err is a 12-bit two's-complement value. It equals the number of reference ticks in the reported period minus the target count, where the tick rate is clock × divisor / 1024. The value holds between strobes.
- R3: spd_err_vld is high for exactly one cycle, once per two complete tachometer periods, and reports the second period of each pair.
- R4: After reset or after a mode change, no strobe appears until two complete periods have elapsed after the first rising edge. The first strobe follows the third rising edge.
- R5: At each strobe, lock_n goes low when |error| ≤ count/16 and high otherwise. For count 1024, errors of +64 and −64 lock and +65 does not.
- R6: Once the running count reaches 2 × count, lock_n goes high at once, without waiting for an edge. A reported period that reached that limit gives spd_err = +2047.
- R7: During and just after reset, spd_err = 0, spd_err_vld = 0 and lock_n = 1.
- R8: A mode change releases lock_n within a few cycles and restarts the sequence described in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that times all logic and the reference accumulator |
| rst_n | input | 1 | Active-low asynchronous reset |
| fg_in | input | 1 | Tachometer pulse, asynchronous; a rising edge ends a period |
| mode_a | input | 1 | Mode select, upper bit |
| mode_b | input | 1 | Mode select, lower bit |
| spd_err | output | 12 | Signed speed error, ticks measured minus target |
| spd_err_vld | output | 1 | One-cycle strobe marking a new spd_err |
| lock_n | output | 1 | Low while the last reported speed is inside the window |

## Verification
The main function is driven with tachometer periods exactly on target, slightly fast and slightly slow, and exactly on the ±1/16 boundary and one tick beyond it. These cases separate an off-by-one error in the window test from a sign error in the subtraction. A period of 3000 clocks in mode 11 drives the counter into saturation. It shows whether lock is dropped mid-period and whether the clamped +2047 code is produced. Each of the four modes is then run with periods that are multiples of the tick spacing. This separates a wrong divisor from a wrong count, and confirms that mode 10 needs a period twice as long. Unequal periods within a pair show which period of the pair is reported. Any strobe that the bench did not predict is flagged, so emitting on the wrong period or too early after a mode change is caught.

// File: rtl/spd_disc_pkg.sv
package spd_disc_pkg;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        ST_WAIT   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } disc_state_e;

endpackage

// File: rtl/spd_sync.sv
// Multi-stage synchronizer for asynchronous level inputs.
module spd_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spd_ref_gen.sv
// Mode decode and fractional reference tick: tick rate = clk * div / 2^REF_LOG2.
module spd_ref_gen #(
    parameter int REF_LOG2 = 10,
    parameter int CNT_W    = 12,
    parameter int CNT_HH   = 1024,
    parameter int DIV_HH   = 1024,
    parameter int CNT_HL   = 1024,
    parameter int DIV_HL   = 512,
    parameter int CNT_LH   = 256,
    parameter int DIV_LH   = 256,
    parameter int CNT_LL   = 512,
    parameter int DIV_LL   = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    output logic             tick,
    output logic [CNT_W-1:0] target
);
    localparam int ACC_W = REF_LOG2 + 1;

    logic [REF_LOG2-1:0] acc;
    logic [ACC_W-1:0]    div;
    logic [ACC_W-1:0]    sum;

    always_comb begin
        unique case (sel)
            2'b11: begin div = ACC_W'(DIV_HH); target = CNT_W'(CNT_HH); end
            2'b10: begin div = ACC_W'(DIV_HL); target = CNT_W'(CNT_HL); end
            2'b01: begin div = ACC_W'(DIV_LH); target = CNT_W'(CNT_LH); end
            default: begin div = ACC_W'(DIV_LL); target = CNT_W'(CNT_LL); end
        endcase
    end

    assign sum  = {1'b0, acc} + div;
    assign tick = sum[REF_LOG2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc <= '0;
        end else begin
            acc <= sum[REF_LOG2-1:0];
        end
    end
endmodule

// File: rtl/spd_period_ctr.sv
// Counts reference ticks since the last boundary, saturating at sat_lim.
module spd_period_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] sat_lim,
    output logic [CNT_W-1:0] meas,
    output logic             at_sat
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   inc;

    // meas includes a tick landing in the boundary cycle itself
    assign inc    = {1'b0, cnt} + (CNT_W+1)'(tick);
    assign meas   = (inc >= {1'b0, sat_lim}) ? sat_lim : inc[CNT_W-1:0];
    assign at_sat = (cnt >= sat_lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear || restart) begin
            cnt <= '0;
        end else begin
            cnt <= meas;
        end
    end
endmodule

// File: rtl/spd_disc.sv
module spd_disc
    import spd_disc_pkg::*;
#(
    parameter int REF_LOG2   = 10,
    parameter int ERR_W      = 12,
    parameter int LOCK_SHIFT = 4,
    parameter int SYNC_STG   = 2,
    parameter int CNT_HH     = 1024,
    parameter int DIV_HH     = 1024,
    parameter int CNT_HL     = 1024,
    parameter int DIV_HL     = 512,
    parameter int CNT_LH     = 256,
    parameter int DIV_LH     = 256,
    parameter int CNT_LL     = 512,
    parameter int DIV_LL     = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fg_in,
    input  logic                    mode_a,
    input  logic                    mode_b,
    output logic signed [ERR_W-1:0] spd_err,
    output logic                    spd_err_vld,
    output logic                    lock_n
);
    // Counter must hold twice the largest target count
    localparam int CNT_W   = REF_LOG2 + 2;
    localparam int ERR_MAX = (2 ** (ERR_W - 1)) - 1;
    localparam int ERR_MIN = -(2 ** (ERR_W - 1));

    logic             fg_s, fg_d, fg_rise;
    logic [1:0]       mode_s, mode_q;
    logic             mode_chg;
    logic             tick;
    logic [CNT_W-1:0] target, sat_lim, meas;
    logic             at_sat;
    disc_state_e      state_q, state_d;
    logic             emit;
    int               diff_i, mag_i, clamp_i;
    logic             sat_hit, in_win;
    logic [ERR_W-1:0] err_val;

    // ---------------- input conditioning ----------------
    spd_sync #(.W(1), .STAGES(SYNC_STG)) u_fg_sync (
        .clk(clk), .rst_n(rst_n), .d(fg_in), .q(fg_s)
    );

    spd_sync #(.W(2), .STAGES(SYNC_STG)) u_mode_sync (
        .clk(clk), .rst_n(rst_n), .d({mode_a, mode_b}), .q(mode_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fg_d   <= 1'b0;
            mode_q <= 2'b00;
        end else begin
            fg_d   <= fg_s;
            mode_q <= mode_s;
        end
    end

    assign fg_rise  = fg_s & ~fg_d;
    assign mode_chg = (mode_s != mode_q);

    // ---------------- reference and counter ----------------
    spd_ref_gen #(
        .REF_LOG2(REF_LOG2), .CNT_W(CNT_W),
        .CNT_HH(CNT_HH), .DIV_HH(DIV_HH), .CNT_HL(CNT_HL), .DIV_HL(DIV_HL),
        .CNT_LH(CNT_LH), .DIV_LH(DIV_LH), .CNT_LL(CNT_LL), .DIV_LL(DIV_LL)
    ) u_ref (
        .clk(clk), .rst_n(rst_n), .sel(mode_q), .tick(tick), .target(target)
    );

    assign sat_lim = target << 1;

    spd_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q == ST_WAIT || mode_chg),
        .restart (fg_rise),
        .tick    (tick),
        .sat_lim (sat_lim),
        .meas    (meas),
        .at_sat  (at_sat)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        if (mode_chg) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT:   if (fg_rise) state_d = ST_FIRST;
                ST_FIRST:  if (fg_rise) state_d = ST_SECOND;
                ST_SECOND: if (fg_rise) state_d = ST_FIRST;
                default:   state_d = ST_WAIT;
            endcase
        end
    end

    assign emit = (state_q == ST_SECOND) && fg_rise && !mode_chg;

    // ---------------- error arithmetic ----------------
    always_comb begin
        diff_i  = int'(meas) - int'(target);
        mag_i   = (diff_i < 0) ? -diff_i : diff_i;
        sat_hit = (meas >= sat_lim);
        in_win  = !sat_hit && (mag_i <= int'(target >> LOCK_SHIFT));
        if (sat_hit)               clamp_i = ERR_MAX;
        else if (diff_i > ERR_MAX) clamp_i = ERR_MAX;
        else if (diff_i < ERR_MIN) clamp_i = ERR_MIN;
        else                       clamp_i = diff_i;
        err_val = ERR_W'(clamp_i);
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spd_err     <= '0;
            spd_err_vld <= 1'b0;
            lock_n      <= 1'b1;
        end else begin
            spd_err_vld <= emit;
            if (emit) begin
                spd_err <= err_val;
                lock_n  <= !in_win;
            end else if (state_q == ST_WAIT || mode_chg || at_sat) begin
                lock_n  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/spd_disc_chk.sv
module spd_disc_chk
    import spd_disc_pkg::*;
#(
    parameter int ERR_W      = 12,
    parameter int CNT_W      = 12,
    parameter int LOCK_SHIFT = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic signed [ERR_W-1:0] spd_err,
    input logic                    spd_err_vld,
    input logic                    lock_n,
    input disc_state_e             state_q,
    input logic [CNT_W-1:0]        target
);
    localparam int ERR_MAX = (2 ** (ERR_W - 1)) - 1;

    int err_i, mag_i, win_i;
    always_comb begin
        err_i = int'(spd_err);
        mag_i = (err_i < 0) ? -err_i : err_i;
        win_i = int'(target >> LOCK_SHIFT);
    end

    // R3
    vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spd_err_vld |=> !spd_err_vld);

    // R4
    vld_from_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spd_err_vld |-> ($past(state_q) == ST_SECOND));

    // R5
    lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_n) |-> spd_err_vld);

    // R5
    lock_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_err_vld && !lock_n) |-> (mag_i <= win_i));

    // R6
    sat_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spd_err_vld && err_i == ERR_MAX) |-> lock_n);

    // R8
    wait_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT) |-> lock_n);
endmodule

bind spd_disc spd_disc_chk #(
    .ERR_W(ERR_W), .CNT_W(CNT_W), .LOCK_SHIFT(LOCK_SHIFT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spd_err    (spd_err),
    .spd_err_vld(spd_err_vld),
    .lock_n     (lock_n),
    .state_q    (state_q),
    .target     (target)
);

// File: tb/spd_disc_tb.sv
module spd_disc_tb;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               fg_in = 1'b0;
    logic               mode_a = 1'b1;
    logic               mode_b = 1'b1;
    logic signed [11:0] spd_err;
    logic               spd_err_vld;
    logic               lock_n;

    int checks = 0;
    int errors = 0;
    int periods = 0;
    int cur_cnt = 1024;
    int cur_div = 1024;
    bit done = 1'b0;
    bit prev_vld = 1'b0;

    int    q_err[$];
    int    q_lock[$];
    string q_tag[$];

    spd_disc u_dut (
        .clk(clk), .rst_n(rst_n), .fg_in(fg_in), .mode_a(mode_a), .mode_b(mode_b),
        .spd_err(spd_err), .spd_err_vld(spd_err_vld), .lock_n(lock_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result of a reported period of p clocks (R1, R2, R5, R6)
    task automatic push_expect(input int p, input string tag);
        int m, e, mag;
        bit sat;
        m   = (p * cur_div) / 1024;
        sat = (m >= 2 * cur_cnt);
        e   = sat ? 2047 : m - cur_cnt;
        mag = (e < 0) ? -e : e;
        q_err.push_back(e);
        q_lock.push_back((!sat && mag <= cur_cnt / 16) ? 0 : 1);
        q_tag.push_back(tag);
    endtask

    task automatic fg_start();
        @(negedge clk);
        fg_in   = 1'b1;
        periods = 0;
    endtask

    task automatic fg_span(input int p, input string tag, input int chk_at);
        for (int i = 1; i <= p; i++) begin
            @(negedge clk);
            if (i == p / 2) fg_in = 1'b0;
            if (i == p) begin
                fg_in = 1'b1;
                periods++;
                if (periods % 2 == 0) push_expect(p, tag);
            end
            // R6: lock released as soon as the count saturates
            if (chk_at != 0 && i == chk_at) check(lock_n == 1'b1, "R6", lock_n, 1);
        end
    endtask

    task automatic set_mode(input bit a, input bit b);
        repeat (5) @(negedge clk);
        fg_in  = 1'b0;
        mode_a = a;
        mode_b = b;
        unique case ({a, b})
            2'b11: begin cur_cnt = 1024; cur_div = 1024; end
            2'b10: begin cur_cnt = 1024; cur_div = 512;  end
            2'b01: begin cur_cnt = 256;  cur_div = 256;  end
            default: begin cur_cnt = 512; cur_div = 512; end
        endcase
        repeat (10) @(negedge clk);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (spd_err_vld) begin
                if (prev_vld) check(1'b0, "R3", 1, 0);
                if (q_err.size() == 0) begin
                    check(1'b0, "R4", int'(spd_err), 0);
                end else begin
                    int e, l;
                    string t;
                    e = q_err.pop_front();
                    l = q_lock.pop_front();
                    t = q_tag.pop_front();
                    check(int'(spd_err) == e, t, int'(spd_err), e);
                    check(int'(lock_n) == l, (t == "R6") ? "R6" : "R5", lock_n, l);
                end
            end
            prev_vld = spd_err_vld;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        // R7: reset values
        check(spd_err_vld == 1'b0, "R7", spd_err_vld, 0);
        check(lock_n == 1'b1, "R7", lock_n, 1);
        check(spd_err == 12'sd0, "R7", int'(spd_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(lock_n == 1'b1, "R7", lock_n, 1);
        set_mode(1'b1, 1'b1);

        // Mode 11: count 1024, divisor 1024
        fg_start();
        fg_span(1024, "R4", 0);
        fg_span(1024, "R1", 0);
        fg_span(1030, "R3", 0);
        fg_span(1000, "R2", 0);
        fg_span(1024, "R5", 0);
        fg_span(1088, "R5", 0);
        fg_span(1024, "R5", 0);
        fg_span(1089, "R5", 0);
        fg_span(1024, "R5", 0);
        fg_span(960,  "R5", 0);
        fg_span(1024, "R6", 0);
        fg_span(3000, "R6", 2100);
        fg_span(1024, "R1", 0);
        fg_span(1024, "R1", 0);
        repeat (8) @(negedge clk);
        check(lock_n == 1'b0, "R5", lock_n, 0);

        // R8: mode change drops lock, restarts the pairing
        set_mode(1'b1, 1'b0);
        check(lock_n == 1'b1, "R8", lock_n, 1);
        check(q_err.size() == 0, "R3", q_err.size(), 0);
        fg_start();
        fg_span(2048, "R8", 0);
        fg_span(2048, "R1", 0);
        fg_span(2048, "R2", 0);
        fg_span(2100, "R2", 0);

        set_mode(1'b0, 1'b1);
        fg_start();
        fg_span(1024, "R4", 0);
        fg_span(1024, "R1", 0);
        fg_span(1024, "R5", 0);
        fg_span(1100, "R5", 0);

        set_mode(1'b0, 1'b0);
        fg_start();
        fg_span(1024, "R4", 0);
        fg_span(1024, "R1", 0);
        fg_span(1024, "R5", 0);
        fg_span(1060, "R5", 0);

        repeat (20) @(negedge clk);
        // R3: every predicted strobe arrived
        check(q_err.size() == 0, "R3", q_err.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule